// File: doc/BRIEF.md
# Paced DMA Handshake Request Controller

This block drives the request line of a peripheral data port that moves 16-bit words between an endpoint FIFO and an external DMA master over an asynchronous request/acknowledge handshake. The request is raised only while the programmed transfer length has bytes left and the FIFO can supply, or accept, at least one whole word. Each rising edge of the acknowledge completes one word and takes two bytes off the remaining length.

A four-bit pacing value N shapes the request. When N is nonzero, the request is held low for N units of about 130 ns after every fourth completed word. The unit is a whole number of clock cycles, derived at elaboration from the clock-frequency parameter and rounded to the nearest integer. A single-word mode also drops the request while the acknowledge is high. Pacing works the same in both modes.

A byte-wide register port holds the pacing value and the 32-bit byte counter. It also gives a 12-bit FIFO level, split into a high and a low byte. For an OUT endpoint the level is the number of bytes held in the FIFO. For an IN endpoint it is the free space in the FIFO. Reading the high byte freezes the low byte, so a high-then-low read pair always returns one coherent value.

Top module: `dmaPaceCtl`

## Requirements
- R1: After reset, every register address (0 to 7) reads 0x00 and the request is low.
- R2: Address 0 holds the pacing value N in bits 3..0. Bits 7..4 are ignored on write and always read as zero.
- R3: The level reads as fifoFill when epIsIn is 0, and as FIFO_BYTES minus fifoFill when epIsIn is 1. Address 1 returns level bits 11..8 in bits 3..0, with bits 7..4 zero.
- R4: A read of address 1 captures level bits 7..0 in that cycle. A later read of address 2 returns the captured byte, even if the level has changed since.
- R5: Addresses 4, 5, 6 and 7 hold byte-counter bits 31..24, 23..16, 15..8 and 7..0. They are read/write, and any 32-bit value can be stored.
- R6: Each rising edge of dmaAck seen while the counter is nonzero lowers the counter by 2, and a counter of 1 becomes 0. An acknowledge edge seen while the counter is zero has no effect.
- R7: The request is low whenever the counter is zero.
- R8: The request is low whenever the level is below 2 bytes.
- R9: With N = 0 the request stays high across word and burst boundaries in multi-word mode, as long as the counter and the level allow it.
- R10: With N nonzero, after every fourth completed word the request stays low for exactly N × U cycles, where U = round(CLK_HZ × 130 ns). It then rises again if the counter and the level allow it.
- R11: With singleMode set, the request is low in any cycle in which dmaAck is high.
- R12: The pacing gap of R10 also applies in single-word mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational on regAddr) |
| epIsIn | input | 1 | Endpoint direction: 1 = IN, 0 = OUT |
| fifoFill | input | 12 | Bytes currently held in the endpoint FIFO |
| singleMode | input | 1 | 1 = single-word handshake, 0 = multi-word |
| dmaAck | input | 1 | Acknowledge from the DMA master |
| dmaReq | output | 1 | DMA request |

## Verification
The bench builds the block with CLK_HZ = 50 MHz, which rounds the unit to 7 cycles. The exact 6.5-cycle product rounds up here, so a floor-based unit would show up as a one-cycle-per-step shortfall in the measured gaps. FIFO_BYTES is set to 512 so that the free-space threshold on an IN endpoint can be reached with small fill values. The bench models the four-word burst phase itself, including words completed in earlier tests. With that model it measures the gaps for N = 2, 15 and 1 against N × 7 cycles, and it confirms that no gap appears when N = 0.

// File: rtl/dmaPacePkg.sv
package dmaPacePkg;

  localparam int CNT_W     = 32;
  localparam int CNT_BYTES = CNT_W / 8;

  localparam logic [2:0] ADDR_LAT    = 3'd0;
  localparam logic [2:0] ADDR_LVL_HI = 3'd1;
  localparam logic [2:0] ADDR_LVL_LO = 3'd2;
  localparam logic [2:0] ADDR_CNT_MS = 3'd4;

  // control -> datapath
  typedef struct packed {
    logic wordDone;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       cntNonZero;
    logic       wordAvail;
    logic [3:0] latency;
  } dpStatus_t;

endpackage

// File: rtl/dmaPaceDatapath.sv
module dmaPaceDatapath
  import dmaPacePkg::*;
#(
  parameter int FIFO_BYTES = 2048,
  parameter int LVL_W      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [2:0]       regAddr,
  input  logic [7:0]       regWdata,
  output logic [7:0]       regRdata,
  input  logic             epIsIn,
  input  logic [LVL_W-1:0] fifoFill,
  input  ctlStrobe_t       strobe,
  output dpStatus_t        status
);

  localparam int HI_W = LVL_W - 8;

  logic [3:0]       latency;
  logic [7:0]       loShadow;
  logic [CNT_W-1:0] count, countNext;
  logic [LVL_W-1:0] levelVal;
  logic [7:0]       cntByte [CNT_BYTES];

  // fill for OUT, free space for IN
  assign levelVal = epIsIn ? (LVL_W'(FIFO_BYTES) - fifoFill) : fifoFill;

  always_comb begin
    countNext = count;
    if (strobe.wordDone)
      countNext = (count < CNT_W'(2)) ? '0 : count - CNT_W'(2);
    for (int i = 0; i < CNT_BYTES; i++)
      if (regWr && regAddr == ADDR_CNT_MS + 3'(CNT_BYTES - 1 - i))
        countNext[8*i +: 8] = regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latency  <= '0;
      loShadow <= '0;
      count    <= '0;
    end else begin
      count <= countNext;
      if (regWr && regAddr == ADDR_LAT)
        latency <= regWdata[3:0];
      if (regRd && regAddr == ADDR_LVL_HI)
        loShadow <= levelVal[7:0];
    end
  end

  // byte lanes of the counter, most significant at the lowest counter address
  for (genvar g = 0; g < CNT_BYTES; g++) begin : gCntLane
    assign cntByte[g] = count[8*(CNT_BYTES-1-g) +: 8];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr[2])
      regRdata = cntByte[regAddr[1:0]];
    else if (regAddr == ADDR_LAT)
      regRdata = {4'b0, latency};
    else if (regAddr == ADDR_LVL_HI)
      regRdata = {{(8-HI_W){1'b0}}, levelVal[LVL_W-1:8]};
    else if (regAddr == ADDR_LVL_LO)
      regRdata = loShadow;
  end

  assign status.cntNonZero = (count != '0);
  assign status.wordAvail  = (levelVal >= LVL_W'(2));
  assign status.latency    = latency;

  // R6: one word takes two bytes off the length, clamped at zero
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wordDone && !(regWr && regAddr[2])) |=>
      (count == (($past(count) < CNT_W'(2)) ? '0 : $past(count) - CNT_W'(2))));

  // R4: low read after high read returns the byte seen at the high read
  a_r4_coherent_pair: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_LVL_LO && $past(regRd && regAddr == ADDR_LVL_HI))
      |-> (regRdata == $past(levelVal[7:0])));

  // R2: reserved pacing bits read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_LAT) |-> (regRdata[7:4] == 4'b0));

endmodule

// File: rtl/dmaPaceControl.sv
module dmaPaceControl
  import dmaPacePkg::*;
#(
  parameter int UNIT_CYC = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaAck,
  input  logic       singleMode,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       dmaReq
);

  localparam int GAP_MAX = 15 * UNIT_CYC;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic             ackQ;
  logic [1:0]       burstPos;
  logic [GAP_W-1:0] gapCnt;
  logic             ackRise, burstEnd;
  logic [GAP_W-1:0] gapLoad;

  assign ackRise         = dmaAck && !ackQ;
  assign strobe.wordDone = ackRise && status.cntNonZero;
  assign burstEnd        = strobe.wordDone && (burstPos == 2'd3);
  assign gapLoad         = GAP_W'(status.latency) * GAP_W'(UNIT_CYC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ     <= 1'b0;
      burstPos <= '0;
      gapCnt   <= '0;
    end else begin
      ackQ <= dmaAck;
      if (strobe.wordDone)
        burstPos <= burstPos + 2'd1;
      if (burstEnd && status.latency != 4'd0)
        gapCnt <= gapLoad;
      else if (gapCnt != '0)
        gapCnt <= gapCnt - GAP_W'(1);
    end
  end

  assign dmaReq = status.cntNonZero && status.wordAvail && (gapCnt == '0)
                  && !(singleMode && dmaAck);

  // R10 / R12: the cycle after a paced burst end carries no request
  a_r10_gap_follows_burst: assert property (@(posedge clk) disable iff (!rstN)
    (burstEnd && status.latency != 4'd0) |=> !dmaReq);

  // R7: a request implies bytes left in the length
  a_r7_req_needs_length: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> status.cntNonZero);

  // R8: a request implies a whole word of data or space
  a_r8_req_needs_word: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> status.wordAvail);

endmodule

// File: rtl/dmaPaceCtl.sv
module dmaPaceCtl
  import dmaPacePkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int          FIFO_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        epIsIn,
  input  logic [11:0] fifoFill,
  input  logic        singleMode,
  input  logic        dmaAck,
  output logic        dmaReq
);

  // 130 ns in cycles, rounded to nearest
  localparam int UNIT_CYC =
    32'((64'(CLK_HZ) * 64'd13 + 64'd50_000_000) / 64'd100_000_000);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  dmaPaceDatapath #(.FIFO_BYTES(FIFO_BYTES), .LVL_W(12)) uDp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .epIsIn(epIsIn), .fifoFill(fifoFill), .strobe(strobe), .status(status)
  );

  dmaPaceControl #(.UNIT_CYC(UNIT_CYC)) uCtl (
    .clk(clk), .rstN(rstN), .dmaAck(dmaAck), .singleMode(singleMode),
    .status(status), .strobe(strobe), .dmaReq(dmaReq)
  );

  // R11: single-word mode never requests while acknowledged
  a_r11_single_drop: assert property (@(posedge clk) disable iff (!rstN)
    (singleMode && dmaAck) |-> !dmaReq);

endmodule

// File: tb/sim_dmaPaceCtl.sv
module sim_dmaPaceCtl;

  localparam int CLK_PERIOD = 10;
  localparam int UNIT       = 7;   // round(50 MHz * 130 ns)

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic        epIsIn = 1'b0;
  logic [11:0] fifoFill = '0;
  logic        singleMode = 1'b0;
  logic        dmaAck = 1'b0;
  logic        dmaReq;

  int vecs  = 0;
  int fails = 0;
  int words = 0;   // words completed so far (bench model of burst phase)

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaPaceCtl #(.CLK_HZ(50_000_000), .FIFO_BYTES(512)) u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .epIsIn(epIsIn),
    .fifoFill(fifoFill), .singleMode(singleMode), .dmaAck(dmaAck),
    .dmaReq(dmaReq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic wrCount(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wrReg(3'(4 + i), v[8*(3-i) +: 8]);
  endtask

  task automatic rdCount(output logic [31:0] v);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      rdReg(3'(4 + i), b);
      v[8*(3-i) +: 8] = b;
    end
  endtask

  // One acknowledge pulse; checks single-mode drop, then either a paced gap
  // of lat*UNIT cycles at a burst end, or an immediate re-request.
  task automatic ackWord(input string tag, input int lat, input logic counted);
    int low;
    @(negedge clk);
    dmaAck = 1'b1;
    #1;
    if (singleMode) chk({tag, " R11 req low while ack high"}, 32'(dmaReq), 0);
    @(negedge clk);
    dmaAck = 1'b0;
    #1;
    if (counted) begin
      if ((words % 4) == 3 && lat != 0) begin
        low = 0;
        while (!dmaReq && low < 400) begin
          low++;
          @(negedge clk);
          #1;
        end
        chk({tag, " gap length"}, 32'(low), 32'(lat * UNIT));
      end else begin
        chk({tag, " req after word"}, 32'(dmaReq), 1);
      end
      words++;
    end
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R1 req after reset", 32'(dmaReq), 0);
    for (int a = 0; a < 8; a++) begin
      rdReg(3'(a), d);
      chk($sformatf("R1 reg %0d after reset", a), 32'(d), 0);
    end
  endtask

  task automatic testLatencyReg();
    logic [7:0] d;
    wrReg(3'd0, 8'hFF);
    rdReg(3'd0, d);
    chk("R2 reserved bits", 32'(d), 32'h0F);
    wrReg(3'd0, 8'hA5);
    rdReg(3'd0, d);
    chk("R2 latency value", 32'(d), 32'h05);
    wrReg(3'd0, 8'h00);
  endtask

  task automatic testLevel();
    logic [7:0] hi, lo;
    epIsIn = 1'b0; fifoFill = 12'h1C7;
    rdReg(3'd1, hi); rdReg(3'd2, lo);
    chk("R3 OUT level hi", 32'(hi), 32'h01);
    chk("R3 OUT level lo", 32'(lo), 32'hC7);
    epIsIn = 1'b1;   // free = 512 - 455 = 57
    rdReg(3'd1, hi); rdReg(3'd2, lo);
    chk("R3 IN free hi", 32'(hi), 32'h00);
    chk("R3 IN free lo", 32'(lo), 32'h39);
    epIsIn = 1'b0; fifoFill = 12'h2AB;
    rdReg(3'd1, hi);
    fifoFill = 12'h0FF;
    rdReg(3'd2, lo);
    chk("R4 hi at capture", 32'(hi), 32'h02);
    chk("R4 lo frozen", 32'(lo), 32'hAB);
  endtask

  task automatic testCountReg();
    logic [31:0] v;
    wrCount(32'h1234_5678);
    rdCount(v);
    chk("R5 count readback", v, 32'h1234_5678);
    wrCount(32'hFFFF_FFFF);
    rdCount(v);
    chk("R5 count max", v, 32'hFFFF_FFFF);
  endtask

  task automatic testCountDown();
    logic [31:0] v;
    epIsIn = 1'b0; fifoFill = 12'd100; singleMode = 1'b0;
    wrCount(32'd3);
    @(negedge clk); #1;
    chk("R8 req with data and length", 32'(dmaReq), 1);
    ackWord("R6 word1", 0, 1'b1);
    rdCount(v);
    chk("R6 count 3->1", v, 32'd1);
    @(negedge clk);
    dmaAck = 1'b1;
    @(negedge clk);
    dmaAck = 1'b0;
    words++;
    rdCount(v);
    chk("R6 count 1->0", v, 32'd0);
    #1 chk("R7 req low at zero", 32'(dmaReq), 0);
    @(negedge clk);
    dmaAck = 1'b1;
    @(negedge clk);
    dmaAck = 1'b0;
    rdCount(v);
    chk("R6 ack at zero ignored", v, 32'd0);
    #1 chk("R7 req stays low", 32'(dmaReq), 0);
  endtask

  task automatic testAvail();
    wrCount(32'd100);
    epIsIn = 1'b0; fifoFill = 12'd1;
    @(negedge clk); #1 chk("R8 OUT 1 byte no req", 32'(dmaReq), 0);
    fifoFill = 12'd2;
    #1 chk("R8 OUT 2 bytes req", 32'(dmaReq), 1);
    epIsIn = 1'b1; fifoFill = 12'd511;
    #1 chk("R8 IN 1 free no req", 32'(dmaReq), 0);
    fifoFill = 12'd510;
    #1 chk("R8 IN 2 free req", 32'(dmaReq), 1);
    epIsIn = 1'b0; fifoFill = 12'd100;
  endtask

  task automatic testNoGap();
    wrReg(3'd0, 8'h00);
    wrCount(32'd1000);
    singleMode = 1'b0;
    for (int i = 0; i < 8; i++) ackWord("R9 no gap", 0, 1'b1);
  endtask

  task automatic testGap(input int lat, input logic single, input string tag);
    logic [31:0] v;
    wrReg(3'd0, 8'(lat));
    wrCount(32'd1000);
    singleMode = single;
    for (int i = 0; i < 8; i++) ackWord(tag, lat, 1'b1);
    rdCount(v);
    chk({tag, " count after 8 words"}, v, 32'd984);
    singleMode = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    testReset();
    testLatencyReg();
    testLevel();
    testCountReg();
    testCountDown();
    testAvail();
    testNoGap();
    testGap(2, 1'b0, "R10 lat2");
    testGap(15, 1'b0, "R10 lat15");
    testGap(1, 1'b1, "R12 single lat1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1-run actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule